// File: doc/BRIEF.md
# Programmable Down-Counting Interrupt Timer

This block is the local timer of a per-core interrupt controller. Software programs it through a small 32-bit register bus: a control word (interrupt vector, mask, timer mode), an initial count, a divide selection, and a read-only view of the live count. A prescaler divides the core clock by a power of two between 1 and 128. The divided strobe steps a 32-bit counter down toward zero.

When the count expires, the block raises an interrupt request that carries the programmed vector. The request is held until the interrupt fabric acknowledges it. In one-shot mode the counter then rests at zero. In periodic mode it restarts from the initial count, so that software sees a steady train of requests. Elapsed time is the initial count minus the current count, multiplied by the divide ratio.

Top module: `irq_timer`

## Requirements
- R1: After reset every register reads zero except the control word, which reads 0x0001_0000 (mask set). irq_valid is low.
- R2: Registers are decoded at byte offsets 0x320 (control), 0x380 (initial count), 0x390 (current count) and 0x3E0 (divide).
  - Read data appears on reg_rdata the cycle after reg_rd is sampled.
  - Reserved bits read zero. The control word keeps only bits 7:0 (vector), bit 16 (mask) and bits 18:17 (mode). The divide word keeps only bits 3, 1 and 0.
  - An unmapped or non-word-aligned address reads zero, and a write to it changes nothing.
- R3: A write to the initial count loads the same value into the current count and restarts the prescaler at phase zero. Writing zero stops the timer.
- R4: Divide codes map as follows: 0xB→1, 0x0→2, 0x1→4, 0x2→8, 0x3→16, 0x8→32, 0x9→64, 0xA→128. With ratio N, the count falls by one every N clocks. A load at edge k gives a count of V−j after edge k+jN.
- R5: In one-shot mode (mode field 0, or any value other than 1), a load of V expires at edge k+V·N. The count then stays at zero.
- R6: In periodic mode (mode field 1), the step that would reach zero instead reloads the initial count. Expiries recur every V·N clocks.
- R7: With the mask bit set, an expiry raises no request, and counting proceeds unchanged.
- R8: An unmasked expiry sets the pending bit (control bit 12, read-only) and drives irq_valid with irq_vector equal to the control vector, starting the cycle after the expiring edge. The request stays up until an edge at which irq_ready is high, and drops after that edge.
- R9: A divide write does not alter the running ratio until the next prescaler wrap, or until the next initial-count load.
- R10: The current count register ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| irq_valid | output | 1 | Interrupt request pending |
| irq_ready | input | 1 | Acknowledge from the interrupt fabric |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
Each result has a fixed latency, and the bench checks each one at its due cycle:
- Read data is due one edge after the read strobe.
- A load at edge k gives a count of V−⌊e/N⌋ after e further edges. The periodic variant of that formula is used in periodic mode.
- irq_valid rises exactly at edge k+V·N.
- irq_valid falls one edge after irq_ready is seen.

The bench keeps its own edge counter. It records the edge number of every write and read, and compares each observed value with the formula evaluated at that edge. The irq line is checked both in the cycle before expiry and in the cycle at expiry, so an off-by-one error in either direction is caught.

The sweep covers all eight divide codes with two initial counts. Further scenarios cover periodic reload, masking, stopping with a zero write, a divide change in the middle of a run, and register decode.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

    localparam int DATA_W    = 32;
    localparam int VEC_W     = 8;
    localparam int DIV_IDX_W = 3;
    localparam int MAX_RATIO = 1 << ((1 << DIV_IDX_W) - 1);
    localparam int RATIO_W   = $clog2(MAX_RATIO) + 1;

    localparam int OFF_CTRL = 'h320;
    localparam int OFF_INIT = 'h380;
    localparam int OFF_CUR  = 'h390;
    localparam int OFF_DIV  = 'h3E0;

    localparam int PEND_BIT = 12;
    localparam int MASK_BIT = 16;
    localparam int MODE_LSB = 17;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_DEADLINE = 2'd2,
        MODE_RSVD     = 2'd3
    } tmode_e;

    typedef struct packed {
        tmode_e             mode;
        logic               mask;
        logic [VEC_W-1:0]   vector;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{mode: MODE_ONESHOT, mask: 1'b1, vector: '0};

    // compact divide index: {code[3], code[1], code[0]}; ratio = 2^((idx+1) mod 8)
    function automatic logic [DIV_IDX_W-1:0] div_pack(input logic [DATA_W-1:0] w);
        return {w[3], w[1], w[0]};
    endfunction

    function automatic logic [DATA_W-1:0] div_unpack(input logic [DIV_IDX_W-1:0] idx);
        return {28'd0, idx[2], 1'b0, idx[1], idx[0]};
    endfunction

    function automatic logic [RATIO_W-1:0] div_ratio(input logic [DIV_IDX_W-1:0] idx);
        logic [DIV_IDX_W-1:0] sh;
        sh = idx + DIV_IDX_W'(1);
        return RATIO_W'(1) << sh;
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.vector = w[VEC_W-1:0];
        c.mask   = w[MASK_BIT];
        c.mode   = tmode_e'(w[MODE_LSB+1:MODE_LSB]);
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c, input logic pend);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VEC_W-1:0]              = c.vector;
        w[PEND_BIT]               = pend;
        w[MASK_BIT]               = c.mask;
        w[MODE_LSB+1:MODE_LSB]    = c.mode;
        return w;
    endfunction

endpackage

// File: rtl/irq_timer_presc.sv
module irq_timer_presc
    import irq_timer_pkg::*;
#(
    parameter int RW = RATIO_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [RW-1:0] ratio_req,
    output logic          tick
);
    localparam int PH_W = RW - 1;

    logic [PH_W-1:0] phase;
    logic [RW-1:0]   act_ratio;

    assign tick = (RW'(phase) == act_ratio - RW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            act_ratio <= RW'(div_ratio('0));
        end else if (restart || tick) begin
            phase     <= '0;
            act_ratio <= ratio_req;
        end else begin
            phase     <= phase + PH_W'(1);
        end
    end

    // R4: phase never runs past the active ratio
    p_phase_bound_r4: assert property (@(posedge clk) disable iff (rst)
        RW'(phase) < act_ratio);

    // R9: ratio only changes at a wrap or a restart
    p_ratio_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> $stable(act_ratio));

endmodule

// File: rtl/irq_timer_cnt.sv
module irq_timer_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);
    logic at_one;

    assign at_one = (cur == CNT_W'(1));
    assign expire = !load && tick && at_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (tick && cur != '0) begin
            if (at_one)
                cur <= periodic ? reload_val : '0;
            else
                cur <= cur - CNT_W'(1);
        end
    end

    // R3: a load takes effect on the next edge
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> cur == $past(load_val));

    // R5: an idle counter stays idle without a load
    p_hold_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cur == '0) |=> cur == '0);

    // R4: one step per strobe
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && tick && cur > CNT_W'(1)) |=> cur == $past(cur) - CNT_W'(1));

    // R6: periodic reload instead of reaching zero
    p_reload_r6: assert property (@(posedge clk) disable iff (rst)
        (expire && periodic) |=> cur == $past(reload_val));

    // R4: no movement between strobes
    p_still_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cur));

endmodule

// File: rtl/irq_timer_regs.sv
module irq_timer_regs
    import irq_timer_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               rd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [CNT_W-1:0]   cur,
    input  logic               expire,
    input  logic               irq_ready,
    output logic               load,
    output logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   init_val,
    output logic               periodic,
    output logic [RATIO_W-1:0] ratio,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vector
);
    logic aligned, hit_ctrl, hit_init, hit_cur, hit_div;
    ctrl_t                ctrl_q;
    logic [CNT_W-1:0]     init_q;
    logic [DIV_IDX_W-1:0] div_q;
    logic                 pend_q;
    logic [DATA_W-1:0]    rmux;

    assign aligned  = (addr[1:0] == 2'b00);
    assign hit_ctrl = aligned && (addr == ADDR_W'(OFF_CTRL));
    assign hit_init = aligned && (addr == ADDR_W'(OFF_INIT));
    assign hit_cur  = aligned && (addr == ADDR_W'(OFF_CUR));
    assign hit_div  = aligned && (addr == ADDR_W'(OFF_DIV));

    assign load       = wr && hit_init;
    assign load_val   = wdata[CNT_W-1:0];
    assign init_val   = init_q;
    assign periodic   = (ctrl_q.mode == MODE_PERIODIC);
    assign ratio      = div_ratio(div_q);
    assign irq_valid  = pend_q;
    assign irq_vector = ctrl_q.vector;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            init_q <= '0;
            div_q  <= '0;
        end else if (wr) begin
            if (hit_ctrl) ctrl_q <= ctrl_from_word(wdata);
            if (hit_init) init_q <= wdata[CNT_W-1:0];
            if (hit_div)  div_q  <= div_pack(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else if (expire && !ctrl_q.mask)
            pend_q <= 1'b1;
        else if (irq_ready)
            pend_q <= 1'b0;
    end

    always_comb begin
        rmux = '0;
        if (hit_ctrl) rmux = ctrl_to_word(ctrl_q, pend_q);
        if (hit_init) rmux = DATA_W'(init_q);
        if (hit_cur)  rmux = DATA_W'(cur);
        if (hit_div)  rmux = div_unpack(div_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd)
            rdata <= rmux;
    end

    // R7: masked expiry never raises a request
    p_mask_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (expire && ctrl_q.mask) |=> !$rose(pend_q));

    // R8: unmasked expiry raises the request
    p_raise_r8: assert property (@(posedge clk) disable iff (rst)
        (expire && !ctrl_q.mask) |=> irq_valid);

    // R8: acknowledge drops the request
    p_ack_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_ready && !expire) |=> !irq_valid);

endmodule

// File: rtl/irq_timer.sv
module irq_timer
    import irq_timer_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_valid,
    input  logic              irq_ready,
    output logic [7:0]        irq_vector
);
    logic               load, periodic, tick, expire;
    logic [CNT_W-1:0]   load_val, init_val, cur;
    logic [RATIO_W-1:0] ratio;

    irq_timer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .cur        (cur),
        .expire     (expire),
        .irq_ready  (irq_ready),
        .load       (load),
        .load_val   (load_val),
        .init_val   (init_val),
        .periodic   (periodic),
        .ratio      (ratio),
        .irq_valid  (irq_valid),
        .irq_vector (irq_vector)
    );

    irq_timer_presc #(.RW(RATIO_W)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .restart   (load),
        .ratio_req (ratio),
        .tick      (tick)
    );

    irq_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_val   (load_val),
        .reload_val (init_val),
        .tick       (tick),
        .periodic   (periodic),
        .cur        (cur),
        .expire     (expire)
    );

endmodule

// File: tb/irq_timer_test.sv
`timescale 1ns/1ps
module irq_timer_test;
    localparam int A_CTRL = 'h320;
    localparam int A_INIT = 'h380;
    localparam int A_CUR  = 'h390;
    localparam int A_DIV  = 'h3E0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, irq_ready = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_timer uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at edge %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 12'(a); reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = 12'(a);
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic ack();
        irq_ready = 1'b1;
        @(posedge clk); @(negedge clk);
        irq_ready = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic [31:0] d;
        int k, nr, v;
        logic [3:0] codes [8];
        logic [7:0] vec;
        codes = '{4'hB, 4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_valid", 32'(irq_valid), 0);
        rd(A_CTRL, d); check("R1 ctrl", d, 32'h0001_0000);
        rd(A_INIT, d); check("R1 init", d, 0);
        rd(A_CUR, d);  check("R1 cur", d, 0);
        rd(A_DIV, d);  check("R1 div", d, 0);

        // R2 decode, reserved bits, unaligned/unmapped
        wr(A_DIV, 32'hFFFF_FFFF); rd(A_DIV, d); check("R2 div reserved", d, 32'h0000_000B);
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); check("R2 ctrl reserved", d, 32'h0007_00FF);
        wr(A_CTRL + 2, 32'h0); rd(A_CTRL, d); check("R2 unaligned write", d, 32'h0007_00FF);
        rd(A_CTRL + 1, d); check("R2 unaligned read", d, 0);
        rd('h300, d); check("R2 unmapped read", d, 0);
        // R10 current count ignores writes
        wr(A_CUR, 32'h0000_1234); rd(A_CUR, d); check("R10 cur write ignored", d, 0);
        wr(A_INIT, 32'hDEAD_BEEF); rd(A_INIT, d); check("R2 init readback", d, 32'hDEAD_BEEF);
        wr(A_INIT, 0); rd(A_CUR, d); check("R3 zero stops", d, 0);
        check("R7 masked no irq", 32'(irq_valid), 0);

        // R4/R5/R8 sweep over all divide codes, one-shot
        for (int i = 0; i < 8; i++) begin
            for (int vi = 0; vi < 2; vi++) begin
                v = 1 + 2 * vi;
                nr = 1 << i;
                vec = 8'(16 * i + v);
                wr(A_CTRL, {24'd0, vec});
                wr(A_DIV, {28'd0, codes[i]});
                wr(A_INIT, 32'(v)); k = cyc;
                if (v * nr >= 2) begin
                    rd(A_CUR, d); check("R3 load value", d, 32'(v));
                end
                if (v == 3 && nr >= 2) begin
                    wait_to(k + nr);
                    rd(A_CUR, d); check("R4 one step after N", d, 2);
                end
                wait_to(k + v * nr - 1);
                check("R5 no early irq", 32'(irq_valid), 0);
                @(negedge clk);
                check("R4 expiry at V*N", 32'(irq_valid), 1);
                check("R8 vector", 32'(irq_vector), 32'(vec));
                rd(A_CTRL, d); check("R8 pending bit", d, 32'h0000_1000 | 32'(vec));
                rd(A_CUR, d); check("R5 rests at zero", d, 0);
                ack();
                check("R8 ack clears", 32'(irq_valid), 0);
            end
        end

        // R6 periodic: N=2, V=3, period 6
        wr(A_CTRL, 32'h0002_0055);
        wr(A_DIV, 32'h0);
        wr(A_INIT, 3); k = cyc;
        wait_to(k + 5); check("R6 no early irq", 32'(irq_valid), 0);
        @(negedge clk); check("R6 first expiry", 32'(irq_valid), 1);
        ack();
        rd(A_CUR, d); check("R6 reloaded", d, 3);
        wait_to(k + 11); check("R6 gap", 32'(irq_valid), 0);
        @(negedge clk); check("R6 second expiry", 32'(irq_valid), 1);
        ack();
        wr(A_INIT, 0);
        rd(A_CUR, d); check("R3 zero stops periodic", d, 0);
        repeat (20) @(negedge clk);
        check("R3 stopped no irq", 32'(irq_valid), 0);

        // R7 masked one-shot: counting continues, no request
        wr(A_CTRL, 32'h0001_0011);
        wr(A_DIV, 32'hB);
        wr(A_INIT, 4); k = cyc;
        wait_to(k + 2);
        rd(A_CUR, d); check("R7 counting continues", d, 2);
        wait_to(k + 10);
        check("R7 masked no irq", 32'(irq_valid), 0);
        rd(A_CUR, d); check("R7 expired", d, 0);

        // R9 divide change waits for the wrap
        wr(A_CTRL, 32'h0000_0021);
        wr(A_DIV, 32'h2);
        wr(A_INIT, 10); k = cyc;
        wr(A_DIV, 32'hB);
        wait_to(k + 6);
        rd(A_CUR, d); check("R9 old ratio holds", d, 10);
        wait_to(k + 11);
        rd(A_CUR, d); check("R9 new ratio after wrap", d, 6);
        wait_to(k + 16); check("R9 no early irq", 32'(irq_valid), 0);
        @(negedge clk); check("R9 expiry", 32'(irq_valid), 1);
        ack();

        finish_up();
    end
endmodule